// File: doc/BRIEF.md
# Flag-Generating 8-Bit Arithmetic Logic Unit

This is a purely combinational arithmetic logic unit for an 8-bit datapath. It takes two operands, a carry/borrow input bit and a 4-bit operation select. It returns a result word, a carry-out and three status flags: signed overflow, zero and sign. Every arithmetic operation shares one adder. A multiplexer in front of the adder picks the adder's second operand: the plain B operand, its complement for subtraction, or an all-zeros or all-ones constant for increment and decrement. Logic and pass-through operations take a separate path that does not use the adder.

The adder has two parts: a 7-bit low section and a final full-adder cell for the sign position. This split exposes the carry that enters the sign bit. Signed overflow is the XOR of the carry into the sign cell and the carry out of it. The rule therefore holds for plain addition, for addition with carry, and for both subtraction forms, with or without a borrow. A decoder turns the operation select into a small set of strobes that steer the operand multiplexer, the carry source and the result multiplexer.

Top module: `flagAlu`

## Requirements
- R1: Select 0 (add) gives result = (A + B) mod 256, and carry-out is bit 8 of the unsigned sum A + B.
- R2: Select 1 (add with carry) gives result = (A + B + carryIn) mod 256, and carry-out is bit 8 of that unsigned sum.
- R3: Select 2 (subtract) gives result = (A − B) mod 256. Carry-out is 1 exactly when no borrow occurs, which means A ≥ B as unsigned values.
- R4: Select 3 (subtract with borrow) gives result = (A − B − carryIn) mod 256. Carry-out is 1 exactly when A ≥ B + carryIn as unsigned values.
- R5: For selects 0, 1, 2, 3, 10 and 11, the overflow flag is 1 exactly when the true two's-complement result of the operation lies outside −128..127. For example, 0x40 − 0xC0 (64 − (−64)) sets it, and 0x7F + 0x01 sets it.
- R6: Select 10 (increment) gives (A + 1) mod 256, with carry-out 1 only when A = 0xFF. Select 11 (decrement) gives (A − 1) mod 256, with carry-out 1 unless A = 0x00.
- R7: Selects 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and NOT A, with carry-out and overflow both 0.
- R8: Select 8 passes A through and select 9 passes B through, with carry-out and overflow both 0.
- R9: Selects 12 to 15 give a result of 0, carry-out 0 and overflow 0, so zero is 1 and sign is 0.
- R10: For every select, zero is 1 exactly when the result is 0x00, and sign equals bit 7 of the result.
- R11: carryIn has no effect on any output for any select other than 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Carry for add-with-carry, borrow for subtract-with-borrow |
| opSel | input | 4 | Operation select |
| result | output | 8 | Operation result |
| carryOut | output | 1 | Adder carry-out for arithmetic selects; 1 means no borrow on subtraction |
| ovf | output | 1 | Signed overflow for arithmetic selects |
| zero | output | 1 | Result is all zeros |
| sign | output | 1 | Bit 7 of the result |

## Verification
The in-design checks assume only that the operand, carry and select inputs are settled two-state values when each combinational evaluation completes. The adder checks hold for any operand pair, because they compare the split adder against a full-width sum and against the sign rule on the adder's own inputs. The decoder checks hold for all sixteen select codes. The stimulus changes inputs only between sample points and never drives X or Z. It sweeps every operand pair and both carry values for the four add/subtract selects, so every input the adder can see on those paths is covered.

// File: rtl/aluPkg.sv
package aluPkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD   = 4'd0;
  localparam logic [OP_W-1:0] OP_ADC   = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd2;
  localparam logic [OP_W-1:0] OP_SBB   = 4'd3;
  localparam logic [OP_W-1:0] OP_AND   = 4'd4;
  localparam logic [OP_W-1:0] OP_OR    = 4'd5;
  localparam logic [OP_W-1:0] OP_XOR   = 4'd6;
  localparam logic [OP_W-1:0] OP_NOTA  = 4'd7;
  localparam logic [OP_W-1:0] OP_PASSA = 4'd8;
  localparam logic [OP_W-1:0] OP_PASSB = 4'd9;
  localparam logic [OP_W-1:0] OP_INC   = 4'd10;
  localparam logic [OP_W-1:0] OP_DEC   = 4'd11;

  // second adder operand source
  typedef enum logic [1:0] {
    BSRC_OPB,
    BSRC_NOTB,
    BSRC_ZERO,
    BSRC_ONES
  } bSrcT;

  // adder carry-in source
  typedef enum logic [1:0] {
    CSRC_ZERO,
    CSRC_ONE,
    CSRC_CI,
    CSRC_NCI
  } cSrcT;

  // result multiplexer source
  typedef enum logic [2:0] {
    RES_SUM,
    RES_AND,
    RES_OR,
    RES_XOR,
    RES_NOTA,
    RES_A,
    RES_B,
    RES_ZERO
  } resSrcT;

  typedef struct packed {
    bSrcT   bSrc;
    cSrcT   cSrc;
    resSrcT resSrc;
    logic   arith;
  } ctrlT;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output ctrlT            strobes
);

  always_comb begin
    strobes = '{bSrc: BSRC_OPB, cSrc: CSRC_ZERO, resSrc: RES_ZERO, arith: 1'b0};
    case (opSel)
      OP_ADD:   strobes = '{bSrc: BSRC_OPB,  cSrc: CSRC_ZERO, resSrc: RES_SUM, arith: 1'b1};
      OP_ADC:   strobes = '{bSrc: BSRC_OPB,  cSrc: CSRC_CI,   resSrc: RES_SUM, arith: 1'b1};
      OP_SUB:   strobes = '{bSrc: BSRC_NOTB, cSrc: CSRC_ONE,  resSrc: RES_SUM, arith: 1'b1};
      OP_SBB:   strobes = '{bSrc: BSRC_NOTB, cSrc: CSRC_NCI,  resSrc: RES_SUM, arith: 1'b1};
      OP_INC:   strobes = '{bSrc: BSRC_ZERO, cSrc: CSRC_ONE,  resSrc: RES_SUM, arith: 1'b1};
      OP_DEC:   strobes = '{bSrc: BSRC_ONES, cSrc: CSRC_ZERO, resSrc: RES_SUM, arith: 1'b1};
      OP_AND:   strobes.resSrc = RES_AND;
      OP_OR:    strobes.resSrc = RES_OR;
      OP_XOR:   strobes.resSrc = RES_XOR;
      OP_NOTA:  strobes.resSrc = RES_NOTA;
      OP_PASSA: strobes.resSrc = RES_A;
      OP_PASSB: strobes.resSrc = RES_B;
      default:  strobes.resSrc = RES_ZERO;
    endcase

    // arithmetic strobes must route the adder sum to the result (R1, R6)
    assert_arith_routes_sum_R1: assert (!strobes.arith || strobes.resSrc == RES_SUM)
      else $error("arith strobe without sum routing");
    // reserved selects must neither use the adder nor produce data (R9)
    assert_reserved_quiet_R9: assert (opSel < 4'd12 || (!strobes.arith && strobes.resSrc == RES_ZERO))
      else $error("reserved select not quiet");
    // carry input only reaches the adder for the carry/borrow selects (R11)
    assert_ci_scope_R11: assert (!(strobes.cSrc inside {CSRC_CI, CSRC_NCI}) || opSel == OP_ADC || opSel == OP_SBB)
      else $error("carry input routed on wrong select");
  end

endmodule

// File: rtl/aluAdder.sv
module aluAdder #(
  parameter int W = 8
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         addCin,
  output logic [W-1:0] addSum,
  output logic         addCout,
  output logic         addOvf
);

  localparam int LOW_W = W - 1;

  logic [W-1:0] lowSum;   // low section, zero-extended; top bit is carry into sign cell
  logic         carryMid;
  logic         topA;
  logic         topB;
  logic [W:0]   refSum;

  always_comb begin
    lowSum   = {1'b0, addA[LOW_W-1:0]} + {1'b0, addB[LOW_W-1:0]} + {{LOW_W{1'b0}}, addCin};
    carryMid = lowSum[LOW_W];
    topA     = addA[W-1];
    topB     = addB[W-1];
    addSum   = {topA ^ topB ^ carryMid, lowSum[LOW_W-1:0]};
    addCout  = (topA & topB) | (carryMid & (topA ^ topB));
    addOvf   = carryMid ^ addCout;

    refSum = {1'b0, addA} + {1'b0, addB} + {{W{1'b0}}, addCin};
    // split adder agrees with a full-width sum (R1, R2)
    assert_split_sum_R2: assert ({addCout, addSum} == refSum)
      else $error("split adder sum mismatch");
    // carry-xor overflow agrees with the sign rule on the adder's own inputs (R5)
    assert_sign_rule_R5: assert (addOvf == ((topA == topB) && (addSum[W-1] != topA)))
      else $error("overflow disagrees with sign rule");
  end

endmodule

// File: rtl/aluLogic.sv
module aluLogic
  import aluPkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] logA,
  input  logic [W-1:0] logB,
  input  resSrcT       logSel,
  output logic [W-1:0] logRes
);

  always_comb begin
    case (logSel)
      RES_AND:  logRes = logA & logB;
      RES_OR:   logRes = logA | logB;
      RES_XOR:  logRes = logA ^ logB;
      RES_NOTA: logRes = ~logA;
      RES_A:    logRes = logA;
      RES_B:    logRes = logB;
      default:  logRes = '0;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  ctrlT         strobes,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic         ovf,
  output logic         zero,
  output logic         sign
);

  logic [W-1:0] adderB;
  logic         adderCin;
  logic [W-1:0] sumVal;
  logic         sumCout;
  logic         sumOvf;
  logic [W-1:0] logicVal;

  always_comb begin
    case (strobes.bSrc)
      BSRC_OPB:  adderB = opB;
      BSRC_NOTB: adderB = ~opB;
      BSRC_ZERO: adderB = '0;
      default:   adderB = '1;
    endcase
    case (strobes.cSrc)
      CSRC_ZERO: adderCin = 1'b0;
      CSRC_ONE:  adderCin = 1'b1;
      CSRC_CI:   adderCin = carryIn;
      default:   adderCin = ~carryIn;
    endcase
  end

  aluAdder #(.W(W)) uAdder (
    .addA   (opA),
    .addB   (adderB),
    .addCin (adderCin),
    .addSum (sumVal),
    .addCout(sumCout),
    .addOvf (sumOvf)
  );

  aluLogic #(.W(W)) uLogic (
    .logA  (opA),
    .logB  (opB),
    .logSel(strobes.resSrc),
    .logRes(logicVal)
  );

  always_comb begin
    result   = (strobes.resSrc == RES_SUM) ? sumVal : logicVal;
    carryOut = strobes.arith & sumCout;
    ovf      = strobes.arith & sumOvf;
    zero     = (result == '0);
    sign     = result[W-1];
  end

endmodule

// File: rtl/flagAlu.sv
module flagAlu
  import aluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [OP_W-1:0]   opSel,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              ovf,
  output logic              zero,
  output logic              sign
);

  ctrlT strobes;

  aluCtrl uCtrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  aluDatapath #(.W(DATA_W)) uPath (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut),
    .ovf     (ovf),
    .zero    (zero),
    .sign    (sign)
  );

endmodule

// File: tb/sim_flagAlu.sv
module sim_flagAlu;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] a = 8'h00;
  logic [7:0] b = 8'h00;
  logic       ci = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] result;
  logic       carryOut, ovf, zero, sign;

  int total = 0;
  int bad = 0;

  flagAlu u0 (
    .opA(a), .opB(b), .carryIn(ci), .opSel(op),
    .result(result), .carryOut(carryOut), .ovf(ovf), .zero(zero), .sign(sign)
  );

  function automatic void model(input int o, input int av, input int bv, input int cv,
                                output int y, output int co, output int v);
    int sa, sb, sv, full;
    bit arith;
    sa = (av > 127) ? av - 256 : av;
    sb = (bv > 127) ? bv - 256 : bv;
    arith = 1'b1; sv = 0; co = 0; y = 0;
    case (o)
      0:  begin full = av + bv;      y = full & 255; co = (full >> 8) & 1; sv = sa + sb; end
      1:  begin full = av + bv + cv; y = full & 255; co = (full >> 8) & 1; sv = sa + sb + cv; end
      2:  begin full = av - bv;      y = full & 255; co = (av >= bv) ? 1 : 0; sv = sa - sb; end
      3:  begin full = av - bv - cv; y = full & 255; co = (av >= bv + cv) ? 1 : 0; sv = sa - sb - cv; end
      10: begin y = (av + 1) & 255; co = (av == 255) ? 1 : 0; sv = sa + 1; end
      11: begin y = (av - 1) & 255; co = (av != 0) ? 1 : 0; sv = sa - 1; end
      default: begin
        arith = 1'b0;
        case (o)
          4: y = av & bv;
          5: y = av | bv;
          6: y = av ^ bv;
          7: y = (~av) & 255;
          8: y = av;
          9: y = bv;
          default: y = 0;
        endcase
      end
    endcase
    v = (arith && (sv > 127 || sv < -128)) ? 1 : 0;
  endfunction

  function automatic string opTag(input int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5, 6, 7: return "R7";
      8, 9: return "R8";
      10, 11: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s op=%0d a=%0h b=%0h ci=%0d actual=%0h expected=%0h",
               tag, what, op, a, b, ci, act, exp);
    end
  endtask

  task automatic applyCheck(input int o, input int av, input int bv, input int cv);
    int ey, eco, ev;
    string tag;
    op = o[3:0]; a = av[7:0]; b = bv[7:0]; ci = cv[0];
    #1;
    model(o, av, bv, cv, ey, eco, ev);
    tag = opTag(o);
    if (cv == 1 && o != 1 && o != 3) tag = {tag, "/R11"};
    cmp(tag, "result", int'(result), ey);
    cmp(tag, "carryOut", int'(carryOut), eco);
    cmp((o inside {0, 1, 2, 3, 10, 11}) ? "R5" : tag, "ovf", int'(ovf), ev);
    cmp("R10", "zero", int'(zero), (ey == 0) ? 1 : 0);
    cmp("R10", "sign", int'(sign), (ey >> 7) & 1);
  endtask

  // idle inputs: 0 + 0 gives a zero result with zero flag set (R1, R10)
  task automatic testIdle();
    #1;
    cmp("R10", "idle zero", int'(zero), 1);
    cmp("R1", "idle result", int'(result), 0);
    applyCheck(0, 0, 0, 0);
  endtask

  // every operand pair and both carry values for one add/subtract select
  task automatic testArithSweep(input int o);
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++)
          applyCheck(o, x, y, c);
  endtask

  // increment/decrement over all A, including the wrap and overflow points (R6)
  task automatic testIncDec();
    for (int x = 0; x < 256; x++)
      for (int c = 0; c < 2; c++) begin
        applyCheck(10, x, x ^ 8'h5A, c);
        applyCheck(11, x, x ^ 8'hA5, c);
      end
  endtask

  // logic and pass selects with several B patterns (R7, R8)
  task automatic testLogicPass();
    for (int o = 4; o <= 9; o++)
      for (int x = 0; x < 256; x++) begin
        applyCheck(o, x, 8'h00, x & 1);
        applyCheck(o, x, 8'hFF, 0);
        applyCheck(o, x, 8'h3C, 1);
        applyCheck(o, x, ((x << 3) | (x >> 5)) & 255, 0);
      end
  endtask

  // reserved selects give a quiet zero (R9)
  task automatic testReserved();
    for (int o = 12; o <= 15; o++) begin
      applyCheck(o, 8'hFF, 8'hFF, 1);
      applyCheck(o, 8'h80, 8'h7F, 0);
      applyCheck(o, 8'h12, 8'h34, 1);
    end
  endtask

  // named signed-overflow corners (R5)
  task automatic testOverflowCorners();
    applyCheck(0, 8'h7F, 8'h01, 0);
    applyCheck(0, 8'h80, 8'h80, 0);
    applyCheck(0, 8'hFF, 8'h01, 0);
    applyCheck(1, 8'h7F, 8'h00, 1);
    applyCheck(2, 8'h40, 8'hC0, 0);
    applyCheck(2, 8'h80, 8'h01, 0);
    applyCheck(3, 8'h80, 8'h00, 1);
    applyCheck(3, 8'h7F, 8'hFF, 1);
    applyCheck(3, 8'h00, 8'h00, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    testIdle();
    testOverflowCorners();
    for (int o = 0; o < 4; o++) testArithSweep(o);
    testIncDec();
    testLogicPass();
    testReserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule